// File: doc/BRIEF.md
# Right-Shift Register with Arithmetic Fill

This block is a small parallel-load register that moves its contents one place toward the least significant end on every rising clock edge, unless a new word is being loaded. The bit that falls off the low end is lost. What enters at the top depends on a fill-mode select. In serial mode the top bit is taken from a one-bit serial input. In sign mode the current top bit is kept, which makes the step an arithmetic halving of a two's-complement value.

An active-low clear acts at once, without waiting for a clock edge, and overrides every other input for as long as it is held low. When the clear is high, a high load input captures the parallel data word on the next rising edge, and loading takes priority over shifting. The register contents drive the output directly.

Top module: `srx_shift_reg`

## Requirements
- R1: Driving `clr_n` low sets `q` to 0000 at once, before any clock edge occurs.
- R2: While `clr_n` is low, `q` stays 0000 across rising edges, whatever `load`, `din`, `arith` and `ser_in` are.
- R3: With `clr_n` high and `load` high, `q` takes the value of `din` at the rising edge. This happens whatever `arith` and `ser_in` are.
- R4: With `clr_n` high and `load` low, each rising edge moves bit i+1 of `q` into bit i for i = 0..2. The previous bit 0 is discarded.
- R5: With `load` low and `arith` = 0 (serial fill), bit 3 of `q` takes the value `ser_in` had at the rising edge.
- R6: With `load` low and `arith` = 1 (sign fill), bit 3 of `q` keeps its value and `ser_in` has no effect.
- R7: These directed steps give the listed results. Load 0011, then shift three times in serial mode with `ser_in` = 1: the result is 1110. Shift twice more with `ser_in` = 0: the result is 0011. Clear, load 1100, then shift twice in sign mode: the result is 1111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| load | input | 1 | Parallel load enable, active high |
| din | input | 4 | Parallel data word |
| arith | input | 1 | Fill select: 0 serial input, 1 copy of sign bit |
| ser_in | input | 1 | Serial bit for the top position in serial mode |
| q | output | 4 | Register contents |

## Verification
The register's state is its output, so any wrong internal value shows on `q` at the first sample after the rising edge that produced it. The fault does not go away. Each later shift moves the bad bit one place lower until it drops out at bit 0. In sign mode a wrong top bit is also copied into every shift that follows. An error in the clear path shows within the same cycle, before any clock edge.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic {
    FILL_SERIAL = 1'b0,
    FILL_SIGN   = 1'b1
  } fill_mode_e;
endpackage

// File: rtl/srx_fill_mux.sv
module srx_fill_mux
  import srx_pkg::*;
(
  input  fill_mode_e mode,
  input  logic       top_bit,
  input  logic       ser_bit,
  output logic       fill_bit
);
  always_comb begin
    unique case (mode)
      FILL_SIGN:   fill_bit = top_bit;
      default:     fill_bit = ser_bit;
    endcase
  end
endmodule

// File: rtl/srx_next_value.sv
module srx_next_value #(
  parameter int W = 4
) (
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic [W-1:0] cur,
  input  logic         fill_bit,
  output logic [W-1:0] nxt
);
  logic [W-1:0] shifted;

  genvar i;
  generate
    for (i = 0; i < W - 1; i++) begin : g_move
      assign shifted[i] = cur[i+1];
    end
  endgenerate
  assign shifted[W-1] = fill_bit;

  assign nxt = load ? din : shifted;
endmodule

// File: rtl/srx_shift_reg.sv
module srx_shift_reg
  import srx_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         arith,
  input  logic         ser_in,
  output logic [W-1:0] q
);
  localparam int MSB = W - 1;

  fill_mode_e   mode;
  logic         fill_bit;
  logic [W-1:0] nxt;
  logic [W-1:0] state_q;

  assign mode = fill_mode_e'(arith);

  srx_fill_mux u_fill (
    .mode     (mode),
    .top_bit  (state_q[MSB]),
    .ser_bit  (ser_in),
    .fill_bit (fill_bit)
  );

  srx_next_value #(.W(W)) u_next (
    .load     (load),
    .din      (din),
    .cur      (state_q),
    .fill_bit (fill_bit),
    .nxt      (nxt)
  );

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) state_q <= '0;
    else        state_q <= nxt;
  end

  assign q = state_q;

  AST_CLEAR_HOLDS: assert property (@(posedge clk) !clr_n |-> q == '0); // R2
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!clr_n)
    load |=> q == $past(din)); // R3
  AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!clr_n)
    !load |=> q[MSB-1:0] == $past(q[MSB:1])); // R4
  AST_SERIAL_FILL: assert property (@(posedge clk) disable iff (!clr_n)
    (!load && !arith) |=> q[MSB] == $past(ser_in)); // R5
  AST_SIGN_FILL: assert property (@(posedge clk) disable iff (!clr_n)
    (!load && arith) |=> $stable(q[MSB])); // R6
endmodule

// File: tb/tb_srx_shift_reg.sv
`timescale 1ns/1ps
module tb_srx_shift_reg;
  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       load = 1'b0;
  logic [3:0] din = '0;
  logic       arith = 1'b0;
  logic       ser_in = 1'b0;
  logic [3:0] q;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [3:0] model = '0;

  srx_shift_reg #(.W(4)) dut (
    .clk(clk), .clr_n(clr_n), .load(load), .din(din),
    .arith(arith), .ser_in(ser_in), .q(q)
  );

  always #2 clk = ~clk;

  function automatic logic [3:0] ref_next(input logic [3:0] cur, input logic ld,
      input logic [3:0] d, input logic ar, input logic si);
    if (ld) return d;
    return {(ar ? cur[3] : si), cur[3:1]};
  endfunction

  task automatic check(input string req, input logic [3:0] exp);
    checks++;
    if (q !== exp) begin
      failures++;
      $display("FAIL %s q=%b expected=%b", req, q, exp);
    end
  endtask

  task automatic step(input logic ld, input logic [3:0] d, input logic ar,
      input logic si, input string req);
    @(negedge clk);
    load = ld; din = d; arith = ar; ser_in = si;
    @(posedge clk);
    model = ref_next(model, ld, d, ar, si);
    #1;
    check(req, model);
  endtask

  task automatic do_clear;
    @(negedge clk);
    #0.5;
    clr_n = 1'b0;
    #0.5;
    model = '0;
    check("R1", 4'b0000);
    load = 1'b1; din = 4'b1011; arith = 1'b1; ser_in = 1'b1;
    for (int k = 0; k < 2; k++) begin
      @(posedge clk); #1;
      check("R2", 4'b0000);
    end
    @(negedge clk);
    clr_n = 1'b1;
    load = 1'b0;
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    #1;
    check("R1", 4'b0000);
    repeat (2) @(posedge clk);
    @(negedge clk);
    clr_n = 1'b1;

    // R7 directed sequence
    step(1'b1, 4'b0011, 1'b0, 1'b0, "R3");
    step(1'b0, 4'b0000, 1'b0, 1'b1, "R5");
    step(1'b0, 4'b0000, 1'b0, 1'b1, "R5");
    step(1'b0, 4'b0000, 1'b0, 1'b1, "R5");
    check("R7", 4'b1110);
    step(1'b0, 4'b0000, 1'b0, 1'b0, "R4");
    step(1'b0, 4'b0000, 1'b0, 1'b0, "R4");
    check("R7", 4'b0011);
    do_clear();
    step(1'b1, 4'b1100, 1'b0, 1'b0, "R3");
    step(1'b0, 4'b0000, 1'b1, 1'b0, "R6");
    step(1'b0, 4'b0000, 1'b1, 1'b0, "R6");
    check("R7", 4'b1111);

    // R6: serial input ignored in sign mode, positive value
    step(1'b1, 4'b0100, 1'b0, 1'b0, "R3");
    step(1'b0, 4'b0000, 1'b1, 1'b1, "R6");
    check("R6", 4'b0010);
    // R3: load wins over shift under sign mode
    step(1'b1, 4'b1001, 1'b1, 1'b1, "R3");
    // R4: bit 0 discarded
    step(1'b0, 4'b0000, 1'b0, 1'b0, "R4");
    check("R4", 4'b0100);

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic ld;
      ld = ($urandom_range(0, 3) == 0);
      step(ld, 4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), ld ? "R3" : "R4");
      if (n % 97 == 50) do_clear();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule